// File: doc/BRIEF.md
# Software Write-Protect Sequence Detector

This block sits in the write path of a byte-wide parallel EEPROM and watches every write event that the strobe logic has already validated. It keeps a single protection flag and recognises two fixed address/data code sequences. One sequence arms a protected write, and that write also turns protection on. The other sequence turns protection off. For every write event the block gives a same-cycle qualifier that tells the page buffer whether to take the byte or drop it.

Each event is one cycle of `wrValid` with an address and a data byte. Bytes that are consumed as steps of a code sequence never reach the buffer. Once the flag is set, a write is accepted only when the three-byte code arrives just before it. The flag is cleared only by the six-byte release code. Consecutive steps of a sequence must arrive within a window of `WINDOW` clock cycles, or the matcher falls back to idle.

Top module: `swp_detector`

## Requirements
- R1: When reset is released the protection flag `protOn` is 0, and a write that is not a code step is allowed (`wrAllow` = 1 in the same cycle).
- R2: A write taken as a code step is never allowed. The steps are: step A is low address 0x5555 with data 0xAA; step B is low address 0x2AAA or 0xAAAA with data 0x55; step C is low address 0x5555 with data 0xA0 (enable) or 0x80 (release branch).
- R3: After A, B and C-with-0xA0, the next write of any address and data is allowed, and `protOn` reads 1 from the following cycle.
- R4: A, B and C-with-0xA0 sent without a following write inside the window leave `protOn` at 0.
- R5: While `protOn` is 1, a write not preceded by A, B, C-with-0xA0 is discarded (`wrAllow` = 0).
- R6: While `protOn` is 1, a write preceded by the three-byte enable code is allowed and `protOn` stays 1.
- R7: The release code A, B, 0x80 at 0x5555, A, B, then 0x20 at 0x5555 clears `protOn` in the cycle after its sixth write. None of its six writes is allowed.
- R8: A write that does not match the expected step sends the matcher back to idle. That write is allowed if and only if `protOn` is 0, and matching restarts from step A on the next write.
- R9: A step that follows the previous step by `WINDOW` cycles continues the sequence. A gap of `WINDOW`+1 cycles returns the matcher to idle.
- R10: Only the low 16 address bits take part in code matching, so an address such as 0x15555 counts as 0x5555.
- R11: `wrAllow` is 0 in every cycle where `wrValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | One-cycle validated write event |
| wrAddr | input | ADDR_W | Address of the write event |
| wrData | input | DATA_W | Data byte of the write event |
| wrAllow | output | 1 | Same-cycle qualifier: pass this write to the page buffer |
| protOn | output | 1 | Protection flag |

## Verification
The enable code is sent with both accepted forms of the second address and with high address bits set. This separates full-address matching from low-16-bit matching. The code is also sent with the protection flag both clear and set, which shows that the armed write passes in either state. Broken sequences are tried at several steps and with the flag in both states, to show that the offending write is judged by the flag and that the matcher restarts cleanly. Gaps of exactly `WINDOW` and `WINDOW`+1 cycles, and a three-byte code left to expire, pin the timeout boundary and show that the code alone does not set the flag.

// File: rtl/swp_pkg.sv
package swp_pkg;

  // Low-16-bit address keys used by the code sequences
  localparam logic [15:0] KEY_ADDR_MID = 16'h5555;
  localparam logic [15:0] KEY_ADDR_ALT0 = 16'h2AAA;
  localparam logic [15:0] KEY_ADDR_ALT1 = 16'hAAAA;

  // Data keys
  localparam logic [7:0] KEY_DATA_OPEN = 8'hAA;
  localparam logic [7:0] KEY_DATA_ECHO = 8'h55;
  localparam logic [7:0] KEY_DATA_LOCK = 8'hA0;
  localparam logic [7:0] KEY_DATA_PREP = 8'h80;
  localparam logic [7:0] KEY_DATA_FREE = 8'h20;

  // Classification of one write event
  typedef enum logic [2:0] {
    TK_NONE,
    TK_OPEN,
    TK_ECHO,
    TK_LOCK,
    TK_PREP,
    TK_FREE
  } tokenT;

  // Matcher position
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HAVE_OPEN,
    ST_HAVE_ECHO,
    ST_ARMED,
    ST_REL_PREP,
    ST_REL_OPEN,
    ST_REL_ECHO
  } stateT;

  // Strobes from control to datapath, at most one set per write
  typedef struct packed {
    logic codeStep;
    logic armedWrite;
    logic releaseDone;
    logic plainWrite;
  } strobeT;

endpackage

// File: rtl/swp_window_timer.sv
module swp_window_timer #(
  parameter int WINDOW = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic expired
);

  localparam int CNT_W = (WINDOW < 2) ? 1 : $clog2(WINDOW);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW - 1);

  logic [CNT_W-1:0] gapCnt;

  // Fires on the last allowed idle cycle when no write shows up
  assign expired = run && !restart && (gapCnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gapCnt <= '0;
    end else if (restart || !run || expired) begin
      gapCnt <= '0;
    end else begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  // The counter is never allowed past the last idle slot
  p_gap_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && gapCnt == LAST) |=> (gapCnt == '0));

endmodule

// File: rtl/swp_ctrl.sv
module swp_ctrl
  import swp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wrValid,
  input  tokenT  token,
  input  logic   expired,
  output logic   seqActive,
  output strobeT strobe
);

  stateT state, stateNext;

  assign seqActive = (state != ST_IDLE);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    if (wrValid) begin
      stateNext = ST_IDLE;
      unique case (state)
        ST_IDLE: begin
          if (token == TK_OPEN) begin
            stateNext = ST_HAVE_OPEN;
            strobe.codeStep = 1'b1;
          end else begin
            strobe.plainWrite = 1'b1;
          end
        end
        ST_HAVE_OPEN: begin
          if (token == TK_ECHO) begin
            stateNext = ST_HAVE_ECHO;
            strobe.codeStep = 1'b1;
          end else begin
            strobe.plainWrite = 1'b1;
          end
        end
        ST_HAVE_ECHO: begin
          if (token == TK_LOCK) begin
            stateNext = ST_ARMED;
            strobe.codeStep = 1'b1;
          end else if (token == TK_PREP) begin
            stateNext = ST_REL_PREP;
            strobe.codeStep = 1'b1;
          end else begin
            strobe.plainWrite = 1'b1;
          end
        end
        ST_ARMED: begin
          strobe.armedWrite = 1'b1;
        end
        ST_REL_PREP: begin
          if (token == TK_OPEN) begin
            stateNext = ST_REL_OPEN;
            strobe.codeStep = 1'b1;
          end else begin
            strobe.plainWrite = 1'b1;
          end
        end
        ST_REL_OPEN: begin
          if (token == TK_ECHO) begin
            stateNext = ST_REL_ECHO;
            strobe.codeStep = 1'b1;
          end else begin
            strobe.plainWrite = 1'b1;
          end
        end
        ST_REL_ECHO: begin
          if (token == TK_FREE) begin
            strobe.releaseDone = 1'b1;
          end else begin
            strobe.plainWrite = 1'b1;
          end
        end
        default: begin
          strobe.plainWrite = 1'b1;
        end
      endcase
    end else if (expired) begin
      stateNext = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  // A window expiry always drops the matcher back to idle
  p_expire_to_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> (state == ST_IDLE));

  // An unmatched write outside the armed slot leaves the matcher idle
  p_mismatch_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wrValid && token == TK_NONE && state != ST_ARMED) |=> (state == ST_IDLE));

  // Each write produces exactly one strobe, no write produces none
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrValid |-> ($countones(strobe) == 1));

endmodule

// File: rtl/swp_datapath.sv
module swp_datapath
  import swp_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  strobeT            strobe,
  output tokenT             token,
  output logic              wrAllow,
  output logic              protOn
);

  localparam int KEY_W = 16;

  logic [KEY_W-1:0] addrKey;
  logic isMid, isAlt;

  assign addrKey = wrAddr[KEY_W-1:0];
  assign isMid   = (addrKey == KEY_ADDR_MID);
  assign isAlt   = (addrKey == KEY_ADDR_ALT0) || (addrKey == KEY_ADDR_ALT1);

  always_comb begin
    token = TK_NONE;
    if (isMid && wrData == DATA_W'(KEY_DATA_OPEN)) token = TK_OPEN;
    else if (isAlt && wrData == DATA_W'(KEY_DATA_ECHO)) token = TK_ECHO;
    else if (isMid && wrData == DATA_W'(KEY_DATA_LOCK)) token = TK_LOCK;
    else if (isMid && wrData == DATA_W'(KEY_DATA_PREP)) token = TK_PREP;
    else if (isMid && wrData == DATA_W'(KEY_DATA_FREE)) token = TK_FREE;
  end

  assign wrAllow = wrValid && (strobe.armedWrite || (strobe.plainWrite && !protOn));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      protOn <= 1'b0;
    end else if (wrValid && strobe.armedWrite) begin
      protOn <= 1'b1;
    end else if (wrValid && strobe.releaseDone) begin
      protOn <= 1'b0;
    end
  end

  p_step_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wrValid && (strobe.codeStep || strobe.releaseDone)) |-> !wrAllow);

  p_guarded_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrValid && protOn && strobe.plainWrite) |-> !wrAllow);

  p_set_by_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(protOn) |-> $past(wrValid && wrAllow));

  p_clear_by_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(protOn) |-> $past(wrValid && !wrAllow));

  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wrValid |-> !wrAllow);

endmodule

// File: rtl/swp_detector.sv
module swp_detector
  import swp_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int WINDOW = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrAllow,
  output logic              protOn
);

  tokenT  token;
  strobeT strobe;
  logic   seqActive;
  logic   expired;

  swp_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrValid (wrValid),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .strobe  (strobe),
    .token   (token),
    .wrAllow (wrAllow),
    .protOn  (protOn)
  );

  swp_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrValid   (wrValid),
    .token     (token),
    .expired   (expired),
    .seqActive (seqActive),
    .strobe    (strobe)
  );

  swp_window_timer #(.WINDOW(WINDOW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (seqActive),
    .restart (wrValid),
    .expired (expired)
  );

endmodule

// File: tb/swp_detector_test.sv
module swp_detector_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 17;
  localparam int DATA_W = 8;
  localparam int WINDOW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrValid = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic wrAllow, protOn;

  int nCheck = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swp_detector #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WINDOW(WINDOW)) uut (
    .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .wrAllow(wrAllow), .protOn(protOn)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nCheck++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; the write is taken at the next rising edge
  task automatic doWrite(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d,
                         logic expAllow, string req);
    wrValid = 1'b1;
    wrAddr  = a;
    wrData  = d;
    #1 chk(req, 32'(wrAllow), 32'(expAllow));
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendLock(logic [ADDR_W-1:0] alt, string req);
    doWrite(17'h05555, 8'hAA, 1'b0, req);
    doWrite(alt,       8'h55, 1'b0, req);
    doWrite(17'h05555, 8'hA0, 1'b0, req);
  endtask

  task automatic sendRelease(string req);
    doWrite(17'h05555, 8'hAA, 1'b0, req);
    doWrite(17'h02AAA, 8'h55, 1'b0, req);
    doWrite(17'h05555, 8'h80, 1'b0, req);
    doWrite(17'h05555, 8'hAA, 1'b0, req);
    doWrite(17'h0AAAA, 8'h55, 1'b0, req);
    doWrite(17'h05555, 8'h20, 1'b0, req);
  endtask

  task automatic t_reset;
    chk("R1 flag after reset", 32'(protOn), 0);
    chk("R11 no write no allow", 32'(wrAllow), 0);
    doWrite(17'h01234, 8'h5A, 1'b1, "R1 plain write open");
  endtask

  task automatic t_enable;
    sendLock(17'h02AAA, "R2 enable steps dropped");
    doWrite(17'h00100, 8'h3C, 1'b1, "R3 armed write passes");
    chk("R3 flag set", 32'(protOn), 1);
    idle(1);
    chk("R11 idle cycle", 32'(wrAllow), 0);
  endtask

  task automatic t_guarded;
    doWrite(17'h00200, 8'h11, 1'b0, "R5 bare write dropped");
    chk("R5 flag kept", 32'(protOn), 1);
    sendLock(17'h0AAAA, "R2 steps while locked");
    doWrite(17'h00204, 8'h22, 1'b1, "R6 coded write passes");
    chk("R6 flag kept", 32'(protOn), 1);
  endtask

  task automatic t_mismatch_locked;
    doWrite(17'h05555, 8'hAA, 1'b0, "R2 step A");
    doWrite(17'h02AAA, 8'h55, 1'b0, "R2 step B");
    doWrite(17'h05555, 8'h77, 1'b0, "R8 wrong step locked");
    doWrite(17'h00300, 8'h33, 1'b0, "R8 no armed slot after break");
    sendLock(17'h02AAA, "R8 restart steps");
    doWrite(17'h00304, 8'h44, 1'b1, "R8 restart then write");
  endtask

  task automatic t_release;
    sendRelease("R7 release steps dropped");
    chk("R7 flag cleared", 32'(protOn), 0);
    doWrite(17'h00400, 8'h55, 1'b1, "R7 open after release");
  endtask

  task automatic t_code_alone;
    sendLock(17'h02AAA, "R4 steps");
    idle(WINDOW + 2);
    chk("R4 flag still clear", 32'(protOn), 0);
    doWrite(17'h00500, 8'h66, 1'b1, "R4 later write plain");
    chk("R4 flag after plain", 32'(protOn), 0);
  endtask

  task automatic t_mismatch_open;
    doWrite(17'h05555, 8'hAA, 1'b0, "R2 step A");
    doWrite(17'h00010, 8'h99, 1'b1, "R8 wrong step open");
    doWrite(17'h02AAA, 8'h55, 1'b1, "R8 matcher idle after break");
  endtask

  task automatic t_window;
    doWrite(17'h05555, 8'hAA, 1'b0, "R9 A");
    idle(WINDOW - 1);
    doWrite(17'h02AAA, 8'h55, 1'b0, "R9 B at full gap");
    idle(WINDOW - 1);
    doWrite(17'h05555, 8'hA0, 1'b0, "R9 C at full gap");
    idle(WINDOW - 1);
    doWrite(17'h00600, 8'h12, 1'b1, "R9 armed write at full gap");
    chk("R9 flag set", 32'(protOn), 1);
    sendRelease("R9 release");
    doWrite(17'h05555, 8'hAA, 1'b0, "R9 A again");
    idle(WINDOW);
    doWrite(17'h02AAA, 8'h55, 1'b1, "R9 B after expiry is plain");
    doWrite(17'h05555, 8'hA0, 1'b1, "R9 C after expiry is plain");
    chk("R9 flag stays clear", 32'(protOn), 0);
  endtask

  task automatic t_alias;
    sendLock(17'h1AAAA, "R10 high bits ignored");
    doWrite(17'h10700, 8'h5E, 1'b1, "R10 armed write");
    chk("R10 flag set", 32'(protOn), 1);
    doWrite(17'h15555, 8'hAA, 1'b0, "R10 rel A");
    doWrite(17'h12AAA, 8'h55, 1'b0, "R10 rel B");
    doWrite(17'h15555, 8'h80, 1'b0, "R10 rel C");
    doWrite(17'h15555, 8'hAA, 1'b0, "R10 rel D");
    doWrite(17'h1AAAA, 8'h55, 1'b0, "R10 rel E");
    doWrite(17'h15555, 8'h20, 1'b0, "R10 rel F");
    chk("R10 flag cleared", 32'(protOn), 0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_enable();
    t_guarded();
    t_mismatch_locked();
    t_release();
    t_code_alone();
    t_mismatch_open();
    t_window();
    t_alias();
    idle(2);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCheck, nFail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nCheck++;
      nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCheck, nFail);
      $finish;
    end
  end

endmodule